// File: doc/BRIEF.md
# Serial Contention Interrupt Arbiter

This block settles which interrupt source answers an interrupt acknowledge cycle. Every source presents a pending request flag, the priority level of that request and a 4-bit arbitration ID. When the acknowledge strobe rises, the arbiter records which sources have a pending request at exactly the acknowledged level, and only those sources take part.

The sources then contend for the acknowledge one ID bit per clock, starting with the most significant bit, on a shared wired-OR line. A source that drives 0 while the line reads 1 drops out. After the last bit, the survivors hold the largest ID present.

A single survivor with a nonzero ID receives a one-hot grant. If the winning ID is zero, or if no source matched the level, the result is a spurious interrupt. If two or more survivors share a nonzero ID, the arbiter raises a duplicate-ID error and grants no source. The result stays in place until the strobe falls.

Top module: `irq_contend_arb`

## Requirements
- R1: After reset, `done_o`, `grant_o`, `spurious_o`, `dup_err_o` and `win_id_o` are all zero.
- R2: A source takes part only when its `src_req_i` bit is 1 and its level field equals `ack_lvl_i` at the clock edge where the strobe is first seen high. Source i uses bits [i*4 +: 4] of `src_id_i` and bits [i*3 +: 3] of `src_lvl_i`.
- R3: Among the participants, the source with the numerically largest ID wins: 4'b1111 is the highest priority and 4'b0001 is the lowest nonzero priority.
- R4: `done_o` rises on the 5th rising clock edge at which `ack_i` is high, counted from the first such edge; this is one capture cycle plus one cycle for each of the 4 ID bits. Before that edge, `grant_o` and the flags stay zero.
- R5: `grant_o` carries at most one set bit, at the winner's index, and `win_id_o` shows the winning ID.
- R6: If no source takes part, or if all participants have ID 0, `spurious_o` is 1 and `grant_o` is 0.
- R7: If two or more participants share the winning nonzero ID, `dup_err_o` is 1 and `grant_o` is 0. Equal IDs below the winning ID do not cause this error.
- R8: The result holds for as long as `ack_i` stays high, even when the inputs change. One clock edge after `ack_i` falls, all outputs return to zero.
- R9: If `ack_i` falls during contention, the arbitration is abandoned and `done_o` does not assert.
- R10: A participant with ID 0 loses to any participant with a nonzero ID.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ack_i | input | 1 | Interrupt acknowledge strobe |
| ack_lvl_i | input | 3 | Level being acknowledged |
| src_req_i | input | 6 | Pending request flag, one bit per source |
| src_lvl_i | input | 18 | Request level, 3 bits per source |
| src_id_i | input | 24 | Arbitration ID, 4 bits per source |
| done_o | output | 1 | Result valid, held while the strobe stays high |
| grant_o | output | 6 | One-hot grant to the winning source |
| spurious_o | output | 1 | No valid responder (winning ID is 0, or no participant) |
| dup_err_o | output | 1 | Two or more sources share the winning nonzero ID |
| win_id_o | output | 4 | ID that survived contention |

## Verification
The contention is driven with several ID mixes:
- a single participant;
- a spread of IDs, where the result shows whether the highest one wins;
- IDs 1111 against 0001, which probes the most and least significant bits;
- a zero ID against 0001, where the zero source must lose.

Level filtering is checked by giving higher IDs to sources that sit at another level or have no pending request; the lower ID at the matching level must still win. Duplicates are placed both at the top, where the error flag must rise, and below a unique top ID, where the grant must stay clean. Further cases cover:
- all participants with ID 0, and no participant at all;
- a strobe dropped in the middle of contention;
- inputs changed while the result is held.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_HOLD = 2'd2
    } arb_state_e;
endpackage

// File: rtl/contend_slice.sv
// One source's participation in bitwise contention on the shared line.
module contend_slice #(
    parameter int ID_W  = 4,
    parameter int BIT_W = 2
) (
    input  logic [ID_W-1:0]  id_i,
    input  logic [BIT_W-1:0] bit_idx_i,
    input  logic             alive_i,
    input  logic             line_i,
    output logic             drive_o,
    output logic             alive_o
);
    logic my_bit;

    always_comb begin
        my_bit  = id_i[bit_idx_i];
        drive_o = alive_i & my_bit;
        // drop out when the line shows a 1 that this source did not drive
        alive_o = alive_i & (my_bit | ~line_i);
    end
endmodule

// File: rtl/contend_result.sv
// Turns the survivor set into grant and flags.
module contend_result #(
    parameter int N_SRC = 6,
    parameter int ID_W  = 4
) (
    input  logic [N_SRC-1:0]      alive_i,
    input  logic [N_SRC*ID_W-1:0] ids_i,
    output logic [N_SRC-1:0]      grant_o,
    output logic                  spur_o,
    output logic                  dup_o,
    output logic [ID_W-1:0]       win_o
);
    localparam int CNT_W = $clog2(N_SRC + 1);

    logic [CNT_W-1:0] cnt;

    always_comb begin
        cnt   = '0;
        win_o = '0;
        for (int i = 0; i < N_SRC; i++) begin
            if (alive_i[i]) begin
                cnt   = cnt + CNT_W'(1);
                win_o = win_o | ids_i[i*ID_W +: ID_W];
            end
        end
        spur_o  = (cnt == '0) || (win_o == '0);
        dup_o   = !spur_o && (cnt > CNT_W'(1));
        grant_o = (!spur_o && !dup_o) ? alive_i : '0;
    end
endmodule

// File: rtl/irq_contend_arb.sv
module irq_contend_arb
    import irq_arb_pkg::*;
#(
    parameter int N_SRC = 6,
    parameter int ID_W  = 4,
    parameter int LVL_W = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   ack_i,
    input  logic [LVL_W-1:0]       ack_lvl_i,
    input  logic [N_SRC-1:0]       src_req_i,
    input  logic [N_SRC*LVL_W-1:0] src_lvl_i,
    input  logic [N_SRC*ID_W-1:0]  src_id_i,
    output logic                   done_o,
    output logic [N_SRC-1:0]       grant_o,
    output logic                   spurious_o,
    output logic                   dup_err_o,
    output logic [ID_W-1:0]        win_id_o
);
    localparam int BIT_W = (ID_W > 1) ? $clog2(ID_W) : 1;
    localparam logic [BIT_W-1:0] TOP_BIT = BIT_W'(ID_W - 1);

    typedef struct packed {
        arb_state_e             st;
        logic [BIT_W-1:0]       bit_idx;
        logic [N_SRC-1:0]       alive;
        logic [N_SRC*ID_W-1:0]  ids;
        logic [N_SRC-1:0]       grant;
        logic                   spur;
        logic                   dup;
        logic [ID_W-1:0]        win;
    } arb_reg_t;

    arb_reg_t r_d, r_q;

    logic [N_SRC-1:0] match;
    logic [N_SRC-1:0] drive;
    logic [N_SRC-1:0] keep;
    logic             wired;
    logic [N_SRC-1:0] ev_grant;
    logic             ev_spur;
    logic             ev_dup;
    logic [ID_W-1:0]  ev_win;

    for (genvar i = 0; i < N_SRC; i++) begin : g_src
        assign match[i] = src_req_i[i] &&
                          (src_lvl_i[i*LVL_W +: LVL_W] == ack_lvl_i);

        contend_slice #(.ID_W(ID_W), .BIT_W(BIT_W)) u_slice (
            .id_i      (r_q.ids[i*ID_W +: ID_W]),
            .bit_idx_i (r_q.bit_idx),
            .alive_i   (r_q.alive[i]),
            .line_i    (wired),
            .drive_o   (drive[i]),
            .alive_o   (keep[i])
        );
    end

    assign wired = |drive;

    contend_result #(.N_SRC(N_SRC), .ID_W(ID_W)) u_result (
        .alive_i (keep),
        .ids_i   (r_q.ids),
        .grant_o (ev_grant),
        .spur_o  (ev_spur),
        .dup_o   (ev_dup),
        .win_o   (ev_win)
    );

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_IDLE: begin
                if (ack_i) begin
                    r_d.st      = ST_RUN;
                    r_d.bit_idx = TOP_BIT;
                    r_d.alive   = match;
                    r_d.ids     = src_id_i;
                end
            end
            ST_RUN: begin
                if (!ack_i) begin
                    r_d.st    = ST_IDLE;
                    r_d.alive = '0;
                end else begin
                    r_d.alive = keep;
                    if (r_q.bit_idx == '0) begin
                        r_d.st    = ST_HOLD;
                        r_d.grant = ev_grant;
                        r_d.spur  = ev_spur;
                        r_d.dup   = ev_dup;
                        r_d.win   = ev_win;
                    end else begin
                        r_d.bit_idx = r_q.bit_idx - BIT_W'(1);
                    end
                end
            end
            ST_HOLD: begin
                if (!ack_i) begin
                    r_d.st    = ST_IDLE;
                    r_d.alive = '0;
                    r_d.grant = '0;
                    r_d.spur  = 1'b0;
                    r_d.dup   = 1'b0;
                    r_d.win   = '0;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign done_o     = (r_q.st == ST_HOLD);
    assign grant_o    = r_q.grant;
    assign spurious_o = r_q.spur;
    assign dup_err_o  = r_q.dup;
    assign win_id_o   = r_q.win;

    assert_grant_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_o));

    assert_grant_nonzero_id_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_o != '0) |-> (win_id_o != '0));

    assert_spur_nogrant_R6: assert property (@(posedge clk) disable iff (!rst_n)
        spurious_o |-> (grant_o == '0) && !dup_err_o);

    assert_dup_nogrant_R7: assert property (@(posedge clk) disable iff (!rst_n)
        dup_err_o |-> (grant_o == '0));

    assert_quiet_before_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> (grant_o == '0) && !spurious_o && !dup_err_o);

    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && ack_i) |=> done_o && $stable(grant_o) && $stable(win_id_o)
                              && $stable(spurious_o) && $stable(dup_err_o));

    assert_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_i |=> !done_o);
endmodule

// File: tb/irq_contend_arb_tb.sv
module irq_contend_arb_tb;
    localparam int N = 6;
    localparam int IW = 4;
    localparam int LW = 3;

    typedef struct {
        logic [N-1:0]  grant;
        logic          spur;
        logic          dup;
        logic [IW-1:0] win;
        string         tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ack = 1'b0;
    logic [LW-1:0]   ack_lvl = '0;
    logic [N-1:0]    req = '0;
    logic [N*LW-1:0] lvls = '0;
    logic [N*IW-1:0] ids = '0;
    logic done;
    logic [N-1:0] grant;
    logic spur, dup;
    logic [IW-1:0] win;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    exp_t sb[$];

    always #2 clk = ~clk;

    irq_contend_arb #(.N_SRC(N), .ID_W(IW), .LVL_W(LW)) u_dut (
        .clk(clk), .rst_n(rst_n), .ack_i(ack), .ack_lvl_i(ack_lvl),
        .src_req_i(req), .src_lvl_i(lvls), .src_id_i(ids),
        .done_o(done), .grant_o(grant), .spurious_o(spur),
        .dup_err_o(dup), .win_id_o(win)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor: on each rising result, pop and compare with the scoreboard
    bit seen = 0;
    always @(negedge clk) begin
        if (done && !seen) begin
            seen = 1;
            if (sb.size() == 0) begin
                check("R4 unexpected result", 1, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check({e.tag, " grant"}, 32'(grant), 32'(e.grant));
                check({e.tag, " spurious"}, 32'(spur), 32'(e.spur));
                check({e.tag, " dup_err"}, 32'(dup), 32'(e.dup));
                check({e.tag, " win_id"}, 32'(win), 32'(e.win));
            end
        end
        if (!done) seen = 0;
    end

    // driver: compute the expected result, run the acknowledge cycle, check timing
    task automatic run_arb(string tag, logic [N-1:0] rq, logic [N*LW-1:0] lv,
                           logic [N*IW-1:0] id, logic [LW-1:0] al);
        exp_t e;
        int cnt = 0;
        int best = -1;
        int bi = 0;
        for (int i = 0; i < N; i++) begin
            if (rq[i] && lv[i*LW +: LW] == al) begin
                int v = int'(id[i*IW +: IW]);
                if (v > best) begin best = v; cnt = 1; bi = i; end
                else if (v == best) cnt++;
            end
        end
        e.tag = tag;
        e.win = (best < 0) ? '0 : IW'(best);
        e.spur = (best <= 0);
        e.dup = !e.spur && cnt > 1;
        e.grant = (!e.spur && !e.dup) ? (N'(1) << bi) : '0;
        sb.push_back(e);
        req = rq; lvls = lv; ids = id; ack_lvl = al;
        ack = 1'b1;
        repeat (IW) @(posedge clk);
        @(negedge clk);
        check({tag, " R4 not early"}, 32'(done), 0);
        @(posedge clk);
        @(negedge clk);
        check({tag, " R4 done on time"}, 32'(done), 1);
    endtask

    task automatic release_ack(string tag);
        ack = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check({tag, " R8 released"}, 32'({done, grant, spur, dup, win}), 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset outputs", 32'({done, grant, spur, dup, win}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle after reset", 32'({done, grant, spur, dup, win}), 0);

        // single participant
        run_arb("R5 single", 6'b000100, {6{3'd4}}, {4'd0, 4'd0, 4'd0, 4'd5, 4'd0, 4'd0}, 3'd4);
        release_ack("R5 single");

        // spread of IDs: 12 wins
        run_arb("R3 spread", 6'b000111, {6{3'd2}}, {4'd0, 4'd0, 4'd0, 4'd12, 4'd9, 4'd3}, 3'd2);
        release_ack("R3 spread");

        // level filtering and request flag
        run_arb("R2 filter", 6'b101011,
                {3'd5, 3'd5, 3'd2, 3'd1, 3'd5, 3'd5},
                {4'd14, 4'd13, 4'd15, 4'd11, 4'd6, 4'd4}, 3'd5);
        release_ack("R2 filter");

        // extremes
        run_arb("R3 extremes", 6'b110000, {6{3'd7}}, {4'd1, 4'd15, 4'd0, 4'd0, 4'd0, 4'd0}, 3'd7);
        release_ack("R3 extremes");

        // zero ID loses to 0001
        run_arb("R10 zero loses", 6'b000011, {6{3'd3}}, {4'd0, 4'd0, 4'd0, 4'd0, 4'd1, 4'd0}, 3'd3);
        release_ack("R10 zero loses");

        // all zero IDs: spurious
        run_arb("R6 all zero", 6'b001110, {6{3'd1}}, '0, 3'd1);
        release_ack("R6 all zero");

        // nobody at the level: spurious
        run_arb("R6 none", 6'b111111, {6{3'd1}}, {6{4'd9}}, 3'd6);
        release_ack("R6 none");

        // duplicate at top
        run_arb("R7 dup top", 6'b011001, {6{3'd4}}, {4'd0, 4'd7, 4'd0, 4'd0, 4'd3, 4'd7}, 3'd4);
        release_ack("R7 dup top");

        // duplicates below a unique top
        run_arb("R7 dup below", 6'b000111, {6{3'd4}}, {4'd0, 4'd0, 4'd0, 4'd9, 4'd5, 4'd5}, 3'd4);
        release_ack("R7 dup below");

        // abort during contention
        req = 6'b000001; lvls = {6{3'd2}}; ids = {4'd0, 4'd0, 4'd0, 4'd0, 4'd0, 4'd8}; ack_lvl = 3'd2;
        ack = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        ack = 1'b0;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            check("R9 abort no result", 32'({done, grant}), 0);
        end

        // hold while inputs change
        run_arb("R8 hold", 6'b000011, {6{3'd6}}, {4'd0, 4'd0, 4'd0, 4'd0, 4'd10, 4'd2}, 3'd6);
        ids = {6{4'd15}}; req = '1; ack_lvl = 3'd0;
        repeat (3) @(negedge clk);
        check("R8 grant held", 32'(grant), 32'(6'b000010));
        check("R8 win held", 32'(win), 32'd10);
        check("R8 done held", 32'(done), 1);
        release_ack("R8 hold");

        check("R4 scoreboard drained", 32'(sb.size()), 0);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule